// File: doc/BRIEF.md
# Serial Converter Front End with Power Sequencing

This block is the digital front end on the device side of a four-channel serial sampling converter. The host starts a frame by pulling chip select low and then supplies sixteen serial clocks. During the first part of each frame the device shifts in a command word. If the command's write flag is set, the command updates a small control register that holds:

- a two-bit power code,
- a two-bit channel select,
- an input-range bit.

Over the same sixteen clocks the device shifts out a result frame. The frame is two zero bits, then the two-bit channel identifier, then a 12-bit sample. The sample comes from the `sample_i` port, which stands in for the analog core.

The block also runs the power sequence and the track/hold control:

- **Normal:** the block stays powered between frames.
- **Full shutdown:** the block stays off until a command changes the power code.
- **Auto shutdown:** the block sleeps after each valid conversion and wakes on the next chip-select fall.

Waking takes a parameterised number of system clock cycles. Any frame that starts before wake-up has finished is flagged as invalid.

Top module: `adc_serial_fe`

## Requirements
- R1: After reset the power state output reads 1 (waking), ready is low, track is high, the data-out enable is low and the range output is 0. The control register resets to power code 11, channel 0, range 0.
- R2: The command is sent MSB first, one bit per falling serial clock, over the first 12 falling edges. Its bit 11 is the write flag, bits 10:9 the power code, bits 8:7 the channel and bit 6 the range; bits 5:0 are ignored. When the write flag is 1, the register updates at the 12th falling edge. The channel is latched into a frame at that frame's chip-select fall, so a new channel appears in the next frame.
- R3: A command with write flag 0 leaves the whole control register unchanged, including the power code.
- R4: The output frame is sent MSB first: two zeros, the 2-bit channel, then the 12-bit sample captured at the chip-select fall. The first bit appears after the chip-select fall, and each following bit appears after a falling serial clock edge.
- R5: A chip-select fall puts the track/hold into hold (track low), unless the block is asleep. Track returns high after the 14th falling serial clock edge.
- R6: The data-out enable is low whenever chip select is high. It also stays low for the whole of any frame that starts in full shutdown.
- R7: Power code 10 moves the block to full shutdown (state 2, track low) at the 16th falling edge. It stays there until a chip-select rise follows a command that changed the power code.
- R8: From full shutdown, a committed power code 11 starts waking (state 1) at the next chip-select rise and not before. Power code 01 moves the block to sleep at that rise.
- R9: Power code 01 moves the block to sleep (state 3, track low) at the 16th falling edge of a valid frame.
- R10: From sleep, a chip-select fall starts waking and sets track high at that edge. That frame is flagged invalid.
- R11: Ready rises WAKE_CYCLES clock cycles after waking starts, and the state becomes 0 (normal). The frame-valid output holds the ready value seen at the frame's chip-select fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| sclk_i | input | 1 | Serial clock, idles high |
| din_i | input | 1 | Serial command data |
| sample_i | input | 12 | Conversion result from the analog core |
| dout_o | output | 1 | Serial result data |
| dout_en_o | output | 1 | Output-driver enable for dout_o |
| track_o | output | 1 | 1 = track, 0 = hold |
| ready_o | output | 1 | Powered and ready to convert |
| frame_ok_o | output | 1 | Current or last frame holds a valid result |
| range_o | output | 1 | Committed range bit |
| pwr_state_o | output | 2 | 0 normal, 1 waking, 2 full shutdown, 3 sleep |

## Verification
The assertions assume that chip select and the serial clock are synchronous to `clk_i` and change slowly enough to be seen as separate edges. They also assume the serial clock idles high and never falls in the same cycle as chip select. The bench keeps within these limits: it drives every serial pin on the falling system clock and holds each serial-clock level for four cycles. It also starts every frame at least four cycles after the serial lines settle. The checks rely on whole sixteen-clock frames, so the stimulus never aborts a frame early.

// File: rtl/adcfe_pkg.sv
package adcfe_pkg;
  localparam int SAMPLE_W  = 12;
  localparam int CHAN_W    = 2;
  localparam int LEAD_W    = 2;
  localparam int FRAME_LEN = LEAD_W + CHAN_W + SAMPLE_W;
  localparam int CMD_BITS  = 12;
  localparam int CMD_USED  = 6;   // write, pm[1:0], chan[1:0], range
  localparam int TRACK_EDGE = 14;

  typedef enum logic [1:0] {
    PS_ON    = 2'd0,
    PS_WAKE  = 2'd1,
    PS_OFF   = 2'd2,
    PS_SLEEP = 2'd3
  } pwr_e;

  localparam logic [1:0] PM_NORMAL = 2'b11;
  localparam logic [1:0] PM_FULL   = 2'b10;
  localparam logic [1:0] PM_AUTO   = 2'b01;

  typedef struct packed {
    logic [1:0]        pm;
    logic [CHAN_W-1:0] chan;
    logic              rng;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{pm: PM_NORMAL, chan: '0, rng: 1'b0};
endpackage

// File: rtl/adcfe_frame.sv
module adcfe_frame
  import adcfe_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cs_ni,
  input  logic                sclk_i,
  input  logic                din_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic                mute_i,
  output logic                frame_start_o,
  output logic                frame_end_o,
  output logic                cs_rise_o,
  output logic                hold_rel_o,
  output ctrl_t               ctrl_o,
  output logic                dout_o,
  output logic                dout_en_o
);
  localparam int CNT_W = $clog2(FRAME_LEN + 1);

  logic                 cs_q, sclk_q, in_frame_q, mute_q;
  logic [CNT_W-1:0]     cnt_q;
  logic [CMD_USED-1:0]  cmd_q;
  logic [FRAME_LEN-1:0] out_q;
  ctrl_t                ctrl_q;
  logic                 cs_fall, sclk_fall, commit;

  assign cs_fall   = cs_q & ~cs_ni;
  assign cs_rise_o = ~cs_q & cs_ni;
  assign sclk_fall = in_frame_q & sclk_q & ~sclk_i & (cnt_q < CNT_W'(FRAME_LEN));
  assign commit    = sclk_fall && (cnt_q == CNT_W'(CMD_BITS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q       <= 1'b1;
      sclk_q     <= 1'b1;
      in_frame_q <= 1'b0;
      mute_q     <= 1'b0;
      cnt_q      <= '0;
      cmd_q      <= '0;
      out_q      <= '0;
      ctrl_q     <= CTRL_RST;
    end else begin
      cs_q   <= cs_ni;
      sclk_q <= sclk_i;
      if (cs_fall) begin
        in_frame_q <= 1'b1;
        cnt_q      <= '0;
        mute_q     <= mute_i;
        out_q      <= {{LEAD_W{1'b0}}, ctrl_q.chan, sample_i};
      end else if (cs_rise_o) begin
        in_frame_q <= 1'b0;
      end else if (sclk_fall) begin
        cnt_q <= cnt_q + 1'b1;
        out_q <= {out_q[FRAME_LEN-2:0], 1'b0};
        if (cnt_q < CNT_W'(CMD_USED)) cmd_q <= {cmd_q[CMD_USED-2:0], din_i};
        if (commit && cmd_q[5]) ctrl_q <= '{pm: cmd_q[4:3], chan: cmd_q[2:1], rng: cmd_q[0]};
      end
    end
  end

  assign frame_start_o = cs_fall;
  assign frame_end_o   = sclk_fall && (cnt_q == CNT_W'(FRAME_LEN - 1));
  assign hold_rel_o    = sclk_fall && (cnt_q == CNT_W'(TRACK_EDGE - 1));
  assign ctrl_o        = ctrl_q;
  assign dout_o        = out_q[FRAME_LEN-1];
  assign dout_en_o     = in_frame_q & ~mute_q;

  a_r6_quiet_deselected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_q |-> !dout_en_o);
  a_r3_no_write_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit && !cmd_q[5]) |=> $stable(ctrl_q));
  a_r4_lead_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_fall |=> !dout_o);
endmodule

// File: rtl/adcfe_power.sv
module adcfe_power
  import adcfe_pkg::*;
#(
  parameter int WAKE_CYCLES = 64
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       frame_start_i,
  input  logic       frame_end_i,
  input  logic       cs_rise_i,
  input  logic       hold_rel_i,
  input  logic [1:0] pm_i,
  output pwr_e       state_o,
  output logic       track_o,
  output logic       ready_o,
  output logic       frame_ok_o
);
  localparam int WK_W = $clog2(WAKE_CYCLES + 1);

  pwr_e            state_q;
  logic [WK_W-1:0] wk_q;
  logic            track_q, ok_q;

  assign ready_o = (state_q == PS_ON);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PS_WAKE;
      wk_q    <= '0;
      track_q <= 1'b1;
      ok_q    <= 1'b0;
    end else begin
      if (state_q == PS_WAKE) begin
        if (wk_q == WK_W'(WAKE_CYCLES - 1)) state_q <= PS_ON;
        else wk_q <= wk_q + 1'b1;
      end
      if (frame_start_i) begin
        ok_q <= ready_o;
        if (state_q == PS_SLEEP) begin
          state_q <= PS_WAKE;
          wk_q    <= '0;
          track_q <= 1'b1;
        end else begin
          track_q <= 1'b0;
        end
      end
      if (hold_rel_i) track_q <= 1'b1;
      if (frame_end_i) begin
        if (pm_i == PM_FULL) begin
          state_q <= PS_OFF;
          track_q <= 1'b0;
        end else if (pm_i == PM_AUTO && ok_q) begin
          state_q <= PS_SLEEP;
          track_q <= 1'b0;
        end
      end
      if (cs_rise_i && state_q == PS_OFF) begin
        if (pm_i == PM_NORMAL) begin
          state_q <= PS_WAKE;
          wk_q    <= '0;
        end else if (pm_i == PM_AUTO) begin
          state_q <= PS_SLEEP;
        end
      end
    end
  end

  assign state_o    = state_q;
  assign track_o    = track_q;
  assign frame_ok_o = ok_q;

  a_r10_sleep_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PS_SLEEP && frame_start_i) |=> (state_q == PS_WAKE && track_q));
  a_r7_off_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PS_OFF && !cs_rise_i) |=> (state_q == PS_OFF));
  a_r11_ready_after_wake: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> ($past(state_q) == PS_WAKE));
  a_r9_auto_sleep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_end_i && pm_i == PM_AUTO && ok_q) |=> (state_q == PS_SLEEP && !track_q));
  a_r5_hold_on_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_start_i && state_q != PS_SLEEP) |=> !track_q);
endmodule

// File: rtl/adc_serial_fe.sv
module adc_serial_fe
  import adcfe_pkg::*;
#(
  parameter int WAKE_CYCLES = 64
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cs_ni,
  input  logic        sclk_i,
  input  logic        din_i,
  input  logic [11:0] sample_i,
  output logic        dout_o,
  output logic        dout_en_o,
  output logic        track_o,
  output logic        ready_o,
  output logic        frame_ok_o,
  output logic        range_o,
  output logic [1:0]  pwr_state_o
);
  logic  frame_start, frame_end, cs_rise, hold_rel;
  ctrl_t ctrl;
  pwr_e  state;

  adcfe_frame u_frame (
    .clk_i, .rst_ni, .cs_ni, .sclk_i, .din_i, .sample_i,
    .mute_i       (state == PS_OFF),
    .frame_start_o(frame_start),
    .frame_end_o  (frame_end),
    .cs_rise_o    (cs_rise),
    .hold_rel_o   (hold_rel),
    .ctrl_o       (ctrl),
    .dout_o, .dout_en_o
  );

  adcfe_power #(.WAKE_CYCLES(WAKE_CYCLES)) u_power (
    .clk_i, .rst_ni,
    .frame_start_i(frame_start),
    .frame_end_i  (frame_end),
    .cs_rise_i    (cs_rise),
    .hold_rel_i   (hold_rel),
    .pm_i         (ctrl.pm),
    .state_o      (state),
    .track_o, .ready_o, .frame_ok_o
  );

  assign range_o     = ctrl.rng;
  assign pwr_state_o = state;
endmodule

// File: tb/sim_adc_serial_fe.sv
module sim_adc_serial_fe;
  logic clk = 1'b0;
  logic rst_n, cs_n, sclk, din;
  logic [11:0] sample;
  logic dout, dout_en, track, ready, frame_ok, rng;
  logic [1:0] pstate;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  adc_serial_fe u0 (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sclk_i(sclk), .din_i(din),
    .sample_i(sample), .dout_o(dout), .dout_en_o(dout_en), .track_o(track),
    .ready_o(ready), .frame_ok_o(frame_ok), .range_o(rng), .pwr_state_o(pstate)
  );

  typedef struct {
    logic [15:0] word;
    logic en, ok, t0, t13, t14;
    logic [1:0] st;
  } frm_t;
  frm_t exp_q[$];
  frm_t got_q[$];

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic run_frame(input logic [11:0] cmd, input logic [11:0] samp, input frm_t e);
    frm_t g;
    exp_q.push_back(e);
    g.en = 1'b0;
    sample = samp;
    tick(1);
    cs_n = 1'b0;
    tick(4);
    for (int i = 0; i < 16; i++) begin
      g.word[15-i] = dout;
      g.en = g.en | dout_en;
      if (i == 0) begin g.ok = frame_ok; g.t0 = track; end
      if (i == 13) g.t13 = track;
      if (i == 14) g.t14 = track;
      din = (i < 12) ? cmd[11-i] : 1'b0;
      tick(4);
      sclk = 1'b0;
      tick(4);
      sclk = 1'b1;
    end
    tick(4);
    g.st = pstate;
    cs_n = 1'b1;
    tick(4);
    got_q.push_back(g);
    check("R6 enable after deselect", {15'd0, dout_en}, 16'd0);
  endtask

  // monitor: pops expected items as results arrive
  initial begin
    forever begin
      frm_t e, g;
      wait (got_q.size() != 0);
      g = got_q.pop_front();
      e = exp_q.pop_front();
      check("R6 data-out enable", {15'd0, g.en}, {15'd0, e.en});
      if (e.en) check("R4/R2 output frame", g.word, e.word);
      check("R11 frame valid flag", {15'd0, g.ok}, {15'd0, e.ok});
      check("R5/R10 track at frame start", {15'd0, g.t0}, {15'd0, e.t0});
      check("R5 hold before 14th edge", {15'd0, g.t13}, {15'd0, e.t13});
      check("R5 track after 14th edge", {15'd0, g.t14}, {15'd0, e.t14});
      check("R7/R8/R9 state at frame end", {14'd0, g.st}, {14'd0, e.st});
    end
  end

  function automatic frm_t mk(input logic [1:0] ch, input logic [11:0] s, input logic en,
                              input logic ok, input logic t0, input logic [1:0] st);
    frm_t f;
    f.word = {2'b00, ch, s};
    f.en = en; f.ok = ok; f.t0 = t0; f.t13 = t0; f.t14 = 1'b1; f.st = st;
    return f;
  endfunction

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b1; din = 1'b0; sample = '0;
    tick(3);
    rst_n = 1'b1;
    tick(2);
    // R1 reset state
    check("R1 state", {14'd0, pstate}, 16'd1);
    check("R1 ready", {15'd0, ready}, 16'd0);
    check("R1 track", {15'd0, track}, 16'd1);
    check("R1 enable", {15'd0, dout_en}, 16'd0);
    check("R1 range", {15'd0, rng}, 16'd0);

    // R11: frame before ready is flagged invalid
    run_frame(12'h000, 12'hA5C, mk(2'd0, 12'hA5C, 1'b1, 1'b0, 1'b0, 2'd0));
    // R2: write pm=11 chan=2 range=1
    run_frame(12'hF40, 12'h3C7, mk(2'd0, 12'h3C7, 1'b1, 1'b1, 1'b0, 2'd0));
    check("R2 range committed", {15'd0, rng}, 16'd1);
    // R3: write flag 0 carrying pm=10 chan=1 range=0 changes nothing
    run_frame(12'h480, 12'hFFF, mk(2'd2, 12'hFFF, 1'b1, 1'b1, 1'b0, 2'd0));
    check("R3 range kept", {15'd0, rng}, 16'd1);
    check("R3 state kept", {14'd0, pstate}, 16'd0);
    // R7: full shutdown, chan=3
    run_frame(12'hDC0, 12'h001, mk(2'd2, 12'h001, 1'b1, 1'b1, 1'b0, 2'd2));
    check("R7 track held", {15'd0, track}, 16'd0);
    tick(100);
    check("R7 stays off", {14'd0, pstate}, 16'd2);
    // R6/R8: wake-up frame in full shutdown is not driven
    run_frame(12'hFC0, 12'h555, mk(2'd3, 12'h555, 1'b0, 1'b0, 1'b0, 2'd2));
    check("R8 waking after rise", {14'd0, pstate}, 16'd1);
    tick(70);
    check("R11 ready after wake", {15'd0, ready}, 16'd1);
    check("R11 normal state", {14'd0, pstate}, 16'd0);
    // R9: auto shutdown, chan=1
    run_frame(12'hAC0, 12'h8E1, mk(2'd3, 12'h8E1, 1'b1, 1'b1, 1'b0, 2'd3));
    check("R9 track held in sleep", {15'd0, track}, 16'd0);
    // R10: dummy frame wakes, invalid, no sleep at its end
    run_frame(12'h000, 12'h246, mk(2'd1, 12'h246, 1'b1, 1'b0, 1'b1, 2'd0));
    // R9: next valid frame sleeps again
    run_frame(12'h000, 12'hBEE, mk(2'd1, 12'hBEE, 1'b1, 1'b1, 1'b0, 2'd3));

    wait (got_q.size() == 0);
    tick(2);
    finish_run();
  end
endmodule